// File: doc/BRIEF.md
# Layered Overlay Compositor with Per-Dot Blending

This block merges four graphics planes, named A to D, with a backdrop layer that carries live external video. It produces one output pixel per input pixel. All five sources arrive aligned on a shared pixel stream. For each plane the stream supplies a colour, an opaque flag, a 6-bit blend weight and a 2-bit attribute. The backdrop supplies a colour and an attribute.

For every pixel the block finds the highest opaque plane in the active stacking order and the next opaque layer beneath it. If no plane under the winner is opaque, that lower layer is the backdrop. The block then mixes the two with the winner's own weight. A region index travels with each pixel and selects one of several stored stacking orders and blend switches. Software rewrites these only while the display is blanked, so that a visible line is never composed with two different orders.

Top module: `ovl_compositor`

## Requirements
- R1: While reset is held and right after it, `out_valid`, `out_pix` and `out_attr` are zero. Every region starts with order D, C, B, A and with blending disabled.
- R2: When blending is disabled for the region, the output colour and attribute are those of the highest opaque plane in the region's order. In the default order D is on top, then C, then B, then A.
- R3: A plane whose opaque bit is 0 is skipped. If no plane is opaque, the output is the backdrop colour and the backdrop attribute.
- R4: When blending is enabled, each 8-bit channel is (w*top + (63-w)*below + 31)/63, using integer division. Here w is the 6-bit weight of the winning plane and the attribute is the winner's.
- R5: A winner weight of 63 yields exactly the winner colour, and a weight of 0 yields exactly the colour of the layer beneath.
- R6: The layer beneath is the next opaque plane after the winner in the active order. If there is none, it is the backdrop.
- R7: `cfg_order` holds one 2-bit plane index per slot: bits [1:0] name the top plane, [3:2] the second, [5:4] the third and [7:6] the bottom. Index 0 is A, 1 is B, 2 is C and 3 is D. The stored order for `pix_region` decides the stacking.
- R8: A configuration write (`cfg_we`) takes effect only in a cycle where `blank` is 1. A write made while `blank` is 0 leaves the region's order and blend switch unchanged.
- R9: A write whose four slots do not name four distinct planes is ignored.
- R10: `cfg_blend` is stored per region. When it is 0, the winner is shown unmixed whatever its weight.
- R11: A pixel presented with `in_valid` high appears on the outputs with `out_valid` high exactly two clock edges later. `out_valid` is low two edges after a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| pix_region | input | 2 | Region index of the current pixel |
| plane_pix | input | 96 | Plane colours, 24 bits each, A in the lowest bits |
| plane_opq | input | 4 | Opaque flag per plane, bit 0 = A |
| plane_wt | input | 24 | 6-bit blend weight per plane, A lowest |
| plane_attr | input | 8 | 2-bit attribute per plane, A lowest |
| bd_pix | input | 24 | Backdrop (external video) colour |
| bd_attr | input | 2 | Backdrop attribute |
| blank | input | 1 | High during blanking; gates configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | 2 | Region addressed by the write |
| cfg_order | input | 8 | New stacking order, four 2-bit plane indices |
| cfg_blend | input | 1 | New blend enable for the region |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 24 | Composited colour |
| out_attr | output | 2 | Attribute of the winning layer |

## Verification
The bench builds the block with its defaults: four planes, four regions, 8-bit channels and 6-bit weights. With those defaults, every stored order can be programmed to a distinct permutation, including fully reversed and interleaved ones. Per-plane weights differ by a fixed step, so the bench can show that the weight used belongs to the winner and not to the layer beneath. Because the weight spans the full 0 to 63 range, both exact endpoints and the rounding of odd mixtures can be reached.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int unsigned PLANES_DEF  = 4;
  localparam int unsigned CHAN_DEF    = 8;
  localparam int unsigned WEIGHT_DEF  = 6;
  localparam int unsigned ATTR_DEF    = 2;
  localparam int unsigned REGIONS_DEF = 4;

  typedef enum logic [1:0] {
    PL_A = 2'd0,
    PL_B = 2'd1,
    PL_C = 2'd2,
    PL_D = 2'd3
  } plane_e;
endpackage

// File: rtl/ovl_order_regs.sv
module ovl_order_regs #(
  parameter int unsigned NPL  = 4,
  parameter int unsigned NREG = 4,
  localparam int unsigned IW  = $clog2(NPL),
  localparam int unsigned RW  = $clog2(NREG),
  localparam int unsigned OW  = NPL * IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blank,
  input  logic          cfg_we,
  input  logic [RW-1:0] cfg_region,
  input  logic [OW-1:0] cfg_order,
  input  logic          cfg_blend,
  input  logic [RW-1:0] rd_region,
  output logic [OW-1:0] rd_order,
  output logic          rd_blend
);

  logic [NREG-1:0][OW-1:0] ord_q, ord_d;
  logic [NREG-1:0]         ben_q, ben_d;
  logic [NPL-1:0]          seen;
  logic                    perm_ok;
  logic                    wr_en;

  function automatic logic [OW-1:0] default_order();
    logic [OW-1:0] o;
    for (int k = 0; k < NPL; k++) o[k*IW +: IW] = IW'(NPL - 1 - k);
    return o;
  endfunction

  always_comb begin
    seen = '0;
    for (int k = 0; k < NPL; k++) seen[cfg_order[k*IW +: IW]] = 1'b1;
    perm_ok = &seen;
  end

  assign wr_en = cfg_we && blank && perm_ok;

  always_comb begin
    ord_d = ord_q;
    ben_d = ben_q;
    if (wr_en) begin
      ord_d[cfg_region] = cfg_order;
      ben_d[cfg_region] = cfg_blend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) ord_q[r] <= default_order();
      ben_q <= '0;
    end else if (wr_en) begin
      ord_q <= ord_d;
      ben_q <= ben_d;
    end
  end

  assign rd_order = ord_q[rd_region];
  assign rd_blend = ben_q[rd_region];

  // R8: writes outside blanking leave the tables untouched
  p_hold_outside_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !blank) |=> ($stable(ord_q) && $stable(ben_q)));

  // R9: a write that is not a permutation is dropped
  p_reject_bad_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !perm_ok) |=> $stable(ord_q));

endmodule

// File: rtl/ovl_resolve.sv
module ovl_resolve #(
  parameter int unsigned NPL = 4,
  parameter int unsigned PW  = 24,
  parameter int unsigned WTW = 6,
  parameter int unsigned ATW = 2,
  localparam int unsigned IW = $clog2(NPL),
  localparam int unsigned OW = NPL * IW
) (
  input  logic [OW-1:0]      order,
  input  logic [NPL*PW-1:0]  pix,
  input  logic [NPL-1:0]     opq,
  input  logic [NPL*WTW-1:0] wt,
  input  logic [NPL*ATW-1:0] attr,
  input  logic [PW-1:0]      bd_pix,
  input  logic [ATW-1:0]     bd_attr,
  output logic [PW-1:0]      top_pix,
  output logic [PW-1:0]      bot_pix,
  output logic [WTW-1:0]     top_wt,
  output logic [ATW-1:0]     top_attr,
  output logic               top_is_plane
);

  logic found_bot;

  always_comb begin
    top_pix      = bd_pix;
    bot_pix      = bd_pix;
    top_wt       = '0;
    top_attr     = bd_attr;
    top_is_plane = 1'b0;
    found_bot    = 1'b0;
    for (int k = 0; k < NPL; k++) begin
      logic [IW-1:0] idx;
      idx = order[k*IW +: IW];
      if (opq[idx]) begin
        if (!top_is_plane) begin
          top_is_plane = 1'b1;
          top_pix      = pix[idx*PW +: PW];
          top_wt       = wt[idx*WTW +: WTW];
          top_attr     = attr[idx*ATW +: ATW];
        end else if (!found_bot) begin
          found_bot = 1'b1;
          bot_pix   = pix[idx*PW +: PW];
        end
      end
    end
  end

endmodule

// File: rtl/ovl_blend.sv
module ovl_blend #(
  parameter int unsigned CH  = 8,
  parameter int unsigned WTW = 6,
  localparam int unsigned AW = CH + WTW + 1
) (
  input  logic [CH-1:0]  top,
  input  logic [CH-1:0]  bot,
  input  logic [WTW-1:0] wt,
  output logic [CH-1:0]  res
);

  localparam logic [AW-1:0] WMAX = AW'((1 << WTW) - 1);
  localparam logic [AW-1:0] HALF = AW'(((1 << WTW) - 1) / 2);

  logic [AW-1:0] acc;

  always_comb begin
    acc = AW'(wt) * AW'(top) + (WMAX - AW'(wt)) * AW'(bot) + HALF;
    res = CH'(acc / WMAX);
  end

endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
  import ovl_pkg::*;
#(
  parameter int unsigned NPL  = PLANES_DEF,
  parameter int unsigned CH   = CHAN_DEF,
  parameter int unsigned WTW  = WEIGHT_DEF,
  parameter int unsigned ATW  = ATTR_DEF,
  parameter int unsigned NREG = REGIONS_DEF,
  localparam int unsigned PW  = 3 * CH,
  localparam int unsigned IW  = $clog2(NPL),
  localparam int unsigned RW  = $clog2(NREG),
  localparam int unsigned OW  = NPL * IW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [RW-1:0]      pix_region,
  input  logic [NPL*PW-1:0]  plane_pix,
  input  logic [NPL-1:0]     plane_opq,
  input  logic [NPL*WTW-1:0] plane_wt,
  input  logic [NPL*ATW-1:0] plane_attr,
  input  logic [PW-1:0]      bd_pix,
  input  logic [ATW-1:0]     bd_attr,
  input  logic               blank,
  input  logic               cfg_we,
  input  logic [RW-1:0]      cfg_region,
  input  logic [OW-1:0]      cfg_order,
  input  logic               cfg_blend,
  output logic               out_valid,
  output logic [PW-1:0]      out_pix,
  output logic [ATW-1:0]     out_attr
);

  localparam logic [WTW-1:0] WFULL = '1;

  logic [OW-1:0]  cur_order;
  logic           cur_blend;
  logic [PW-1:0]  r_top, r_bot;
  logic [WTW-1:0] r_wt;
  logic [ATW-1:0] r_attr;
  logic           r_is_plane;

  // stage 1 registers
  logic           s1_vld;
  logic [PW-1:0]  s1_top, s1_bot;
  logic [WTW-1:0] s1_wt;
  logic [ATW-1:0] s1_attr;
  logic           s1_mix, s1_mix_d;
  logic [PW-1:0]  mix_pix, s2_pix_d;

  ovl_order_regs #(.NPL(NPL), .NREG(NREG)) u_order (
    .clk        (clk),
    .rst_n      (rst_n),
    .blank      (blank),
    .cfg_we     (cfg_we),
    .cfg_region (cfg_region),
    .cfg_order  (cfg_order),
    .cfg_blend  (cfg_blend),
    .rd_region  (pix_region),
    .rd_order   (cur_order),
    .rd_blend   (cur_blend)
  );

  ovl_resolve #(.NPL(NPL), .PW(PW), .WTW(WTW), .ATW(ATW)) u_resolve (
    .order        (cur_order),
    .pix          (plane_pix),
    .opq          (plane_opq),
    .wt           (plane_wt),
    .attr         (plane_attr),
    .bd_pix       (bd_pix),
    .bd_attr      (bd_attr),
    .top_pix      (r_top),
    .bot_pix      (r_bot),
    .top_wt       (r_wt),
    .top_attr     (r_attr),
    .top_is_plane (r_is_plane)
  );

  assign s1_mix_d = cur_blend && r_is_plane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_top  <= '0;
      s1_bot  <= '0;
      s1_wt   <= '0;
      s1_attr <= '0;
      s1_mix  <= 1'b0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_top  <= r_top;
        s1_bot  <= r_bot;
        s1_wt   <= r_wt;
        s1_attr <= r_attr;
        s1_mix  <= s1_mix_d;
      end
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_chan
    ovl_blend #(.CH(CH), .WTW(WTW)) u_blend (
      .top (s1_top[c*CH +: CH]),
      .bot (s1_bot[c*CH +: CH]),
      .wt  (s1_wt),
      .res (mix_pix[c*CH +: CH])
    );
  end

  assign s2_pix_d = s1_mix ? mix_pix : s1_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_attr  <= '0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_pix  <= s2_pix_d;
        out_attr <= s1_attr;
      end
    end
  end

  // R11: fixed two-edge latency of the valid flag
  p_valid_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  p_idle_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  // R5: weight endpoints give one layer exactly
  p_full_weight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_mix && s1_wt == WFULL) |=> out_pix == $past(s1_top));
  p_zero_weight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_mix && s1_wt == '0) |=> out_pix == $past(s1_bot));

  // R10: blending off shows the winner unmixed
  p_no_mix_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !s1_mix) |=> out_pix == $past(s1_top));

  // R4: a mixed channel never leaves the span of its two inputs
  p_mix_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_mix) |=>
      ((out_pix[CH-1:0] >= $past(s1_top[CH-1:0]) || out_pix[CH-1:0] >= $past(s1_bot[CH-1:0])) &&
       (out_pix[CH-1:0] <= $past(s1_top[CH-1:0]) || out_pix[CH-1:0] <= $past(s1_bot[CH-1:0]))));

endmodule

// File: tb/test_ovl_compositor.sv
module test_ovl_compositor;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  pix_region;
  logic [95:0] plane_pix;
  logic [3:0]  plane_opq;
  logic [23:0] plane_wt;
  logic [7:0]  plane_attr;
  logic [23:0] bd_pix;
  logic [1:0]  bd_attr;
  logic        blank;
  logic        cfg_we;
  logic [1:0]  cfg_region;
  logic [7:0]  cfg_order;
  logic        cfg_blend;
  logic        out_valid;
  logic [23:0] out_pix;
  logic [1:0]  out_attr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench copy of the intended configuration
  logic [7:0] b_ord [4];
  logic       b_ben [4];

  // stimulus table: {region[11:10], opaque[9:6], weight base[5:0]}
  localparam logic [11:0] VEC [16] = '{
    {2'd0, 4'hF, 6'd0},   // R2 default order, D wins
    {2'd0, 4'h7, 6'd0},   // R3 D skipped, C wins
    {2'd0, 4'h0, 6'd0},   // R3 backdrop only
    {2'd0, 4'h1, 6'd0},   // R3 only A
    {2'd1, 4'hF, 6'd0},   // R7 R5 A on top, weight 0 -> B
    {2'd1, 4'hF, 6'd63},  // R7 R5 A weight 63 -> A
    {2'd1, 4'hE, 6'd20},  // R4 R6 B over C
    {2'd1, 4'h8, 6'd40},  // R6 D over backdrop
    {2'd2, 4'hF, 6'd30},  // R7 R10 B on top, no mixing
    {2'd2, 4'hD, 6'd30},  // R7 B missing, D next
    {2'd3, 4'hF, 6'd15},  // R5 D weight 63
    {2'd3, 4'hF, 6'd16},  // R5 D weight 0 -> C
    {2'd3, 4'h9, 6'd25},  // R6 D over A
    {2'd3, 4'h5, 6'd33},  // R4 C weight 1 over A
    {2'd3, 4'h0, 6'd10},  // R3 backdrop
    {2'd3, 4'h4, 6'd47}   // R4 R6 C over backdrop
  };

  ovl_compositor i_ovl_compositor (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .pix_region (pix_region),
    .plane_pix  (plane_pix),
    .plane_opq  (plane_opq),
    .plane_wt   (plane_wt),
    .plane_attr (plane_attr),
    .bd_pix     (bd_pix),
    .bd_attr    (bd_attr),
    .blank      (blank),
    .cfg_we     (cfg_we),
    .cfg_region (cfg_region),
    .cfg_order  (cfg_order),
    .cfg_blend  (cfg_blend),
    .out_valid  (out_valid),
    .out_pix    (out_pix),
    .out_attr   (out_attr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] mix8(logic [7:0] t, logic [7:0] b, logic [5:0] w);
    int acc;
    acc = int'(w) * int'(t) + (63 - int'(w)) * int'(b) + 31;
    return 8'(acc / 63);
  endfunction

  function automatic logic [5:0] wt_of(int p, logic [5:0] base);
    return 6'((int'(base) + 16 * p) % 64);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [1:0] r, logic [7:0] o, logic b, logic blk);
    @(negedge clk);
    blank = blk; cfg_we = 1'b1; cfg_region = r; cfg_order = o; cfg_blend = b;
    @(negedge clk);
    cfg_we = 1'b0; blank = 1'b0;
  endtask

  // expected pixel and attribute from the requirement rules
  task automatic model(logic [1:0] r, logic [3:0] opq, logic [5:0] base,
                       output logic [23:0] ep, output logic [1:0] ea);
    int top_p = -1;
    int bot_p = -1;
    logic [23:0] tp, bp;
    for (int k = 0; k < 4; k++) begin
      int idx = int'(b_ord[r][k*2 +: 2]);
      if (opq[idx]) begin
        if (top_p < 0) top_p = idx;
        else if (bot_p < 0) bot_p = idx;
      end
    end
    if (top_p < 0) begin
      ep = bd_pix; ea = bd_attr;
    end else begin
      tp = plane_pix[top_p*24 +: 24];
      bp = (bot_p < 0) ? bd_pix : plane_pix[bot_p*24 +: 24];
      ea = plane_attr[top_p*2 +: 2];
      if (b_ben[r]) begin
        for (int c = 0; c < 3; c++)
          ep[c*8 +: 8] = mix8(tp[c*8 +: 8], bp[c*8 +: 8], wt_of(top_p, base));
      end else ep = tp;
    end
  endtask

  task automatic run_vec(string req, logic [1:0] r, logic [3:0] opq, logic [5:0] base);
    logic [23:0] ep;
    logic [1:0]  ea;
    @(negedge clk);
    pix_region = r; plane_opq = opq; in_valid = 1'b1;
    for (int p = 0; p < 4; p++) plane_wt[p*6 +: 6] = wt_of(p, base);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #2;
    model(r, opq, base, ep, ea);
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " pixel"}, 32'(out_pix), 32'(ep));
    check({req, " attr"}, 32'(out_attr), 32'(ea));
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; pix_region = '0;
    plane_pix  = {24'hFE0299, 24'h33CC7F, 24'hF04001, 24'h1080FF}; // D C B A
    plane_attr = {2'd0, 2'd3, 2'd2, 2'd1};
    plane_opq  = '0; plane_wt = '0;
    bd_pix = 24'h00FF55; bd_attr = 2'd2;
    blank = 1'b0; cfg_we = 1'b0; cfg_region = '0; cfg_order = '0; cfg_blend = 1'b0;
    for (int r = 0; r < 4; r++) begin b_ord[r] = 8'h1B; b_ben[r] = 1'b0; end

    repeat (3) @(posedge clk);
    #2;
    check("R1 valid in reset", 32'(out_valid), 32'd0);
    check("R1 pixel in reset", 32'(out_pix), 32'd0);
    check("R1 attr in reset", 32'(out_attr), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check("R1 valid after reset", 32'(out_valid), 32'd0);

    // R1 R2 default order before any write
    run_vec("R1 default order", 2'd0, 4'hF, 6'd0);

    // R8 region tables loaded during blanking
    write_cfg(2'd1, 8'hE4, 1'b1, 1'b1); b_ord[1] = 8'hE4; b_ben[1] = 1'b1;
    write_cfg(2'd2, 8'h8D, 1'b0, 1'b1); b_ord[2] = 8'h8D; b_ben[2] = 1'b0;
    write_cfg(2'd3, 8'h1B, 1'b1, 1'b1); b_ord[3] = 8'h1B; b_ben[3] = 1'b1;

    for (int i = 0; i < 16; i++)
      run_vec($sformatf("vec%0d R2 R4 R7", i), VEC[i][11:10], VEC[i][9:6], VEC[i][5:0]);

    // R8 write outside blanking is ignored
    write_cfg(2'd1, 8'h1B, 1'b0, 1'b0);
    run_vec("R8 write outside blank", 2'd1, 4'hF, 6'd63);

    // R9 non-permutation write is ignored
    write_cfg(2'd2, 8'h00, 1'b1, 1'b1);
    run_vec("R9 bad order", 2'd2, 4'hF, 6'd30);

    // R10 blending switched off for region 3 with a mid weight
    write_cfg(2'd3, 8'h1B, 1'b0, 1'b1); b_ben[3] = 1'b0;
    run_vec("R10 blend off", 2'd3, 4'hF, 6'd0);

    // R11 single pulse latency
    @(negedge clk);
    in_valid = 1'b1;
    @(posedge clk); #2;
    check("R11 one edge", 32'(out_valid), 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #2;
    check("R11 two edges", 32'(out_valid), 32'd1);
    @(posedge clk); #2;
    check("R11 three edges", 32'(out_valid), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule